// File: doc/BRIEF.md
# Shutdown and Output-Enable Pin Controller

This block turns one external control pin into drive commands for a set of clock outputs. A configuration bit chooses how the pin is read. In shutdown mode a high pin powers the outputs down. In enable mode the pin gates the outputs, and a second configuration bit sets which pin level counts as "enabled". The pin has a weak pull-down, so an unconnected pin reads low. With the default settings (enable mode, active-low polarity) a low pin leaves the outputs running.

The block serves a parameterised number of differential pairs and single-ended outputs. For each one it produces three signals: an enable, a high-impedance control and a forced level. For a pair, the forced level is the level of the true leg, and the complement leg is its inverse. When an output is disabled in enable mode, its own two-bit selection decides whether it floats or is held at a fixed level. Shutdown ignores that selection and holds every output low.

The asynchronous pin passes through a two-stage synchroniser before it is used. So that no output emits a shortened pulse, an output's enable and disable changes take effect only on clock edges where that output's clock is low. Shutdown is the one exception: it acts at once. A power-down status output reports when shutdown is in force.

Top module: `sdoe_ctrl`

## Requirements
- R1: A change of `ctl_pin` reaches the outputs on the third rising `clk` edge after the pin is stable: two edges through the synchroniser, then one to register the drive state.
- R2: When `cfg_sd_mode`=1 and the synchronised pin is 1, every output on the next edge has en=0, hiz=0 and lvl=0. For a pair this means the true leg is low and the complement is high. The disabled-state selections have no effect.
- R3: When `cfg_sd_mode`=1, `cfg_oe_high` has no effect. A low synchronised pin lets the outputs run.
- R4: When `cfg_sd_mode`=0, outputs are enabled when the synchronised pin is 0 and `cfg_oe_high`=0, or when the pin is 1 and `cfg_oe_high`=1. In every other case they are disabled.
- R5: A disabled output in enable mode follows its 2-bit selection. Code 00 gives hiz=1. Code 01 drives lvl=0. Code 10 drives lvl=1. Code 11 gives hiz=1. In all of these en=0. A running output has en=1, hiz=0 and lvl=0.
- R6: Outside shutdown, an output's drive state changes only on edges where its clock level input is 0. On edges where that input is 1, the output holds its drive state.
- R7: Shutdown takes effect on the next edge whatever the output clock levels are. Leaving shutdown follows R6.
- R8: `pd_status` is 1 exactly when shutdown is in force. It takes the same latency as the outputs.
- R9: During reset, and after it, the synchroniser reads the pin as low. While `rst` is 1, all outputs are en=0, hiz=0, lvl=0 and `pd_status`=0.
- R10: Each output is gated only by its own clock level. Outputs whose clocks are low update while the others hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pin | input | 1 | Asynchronous shutdown/enable pin level |
| cfg_sd_mode | input | 1 | 1: pin acts as shutdown; 0: pin acts as output enable |
| cfg_oe_high | input | 1 | Enable-mode polarity; 0 = enabled when pin low |
| dp_clk_lvl | input | N_DIFF | Current level of each pair's clock |
| se_clk_lvl | input | N_SE | Current level of each single-ended clock |
| dp_dis_sel | input | 2*N_DIFF | Disabled-state code per pair, pair i at bits [2i+1:2i] |
| se_dis_sel | input | 2*N_SE | Disabled-state code per single-ended output |
| dp_en | output | N_DIFF | Pair running |
| dp_hiz | output | N_DIFF | Pair high impedance |
| dp_lvl | output | N_DIFF | Forced level of pair true leg |
| se_en | output | N_SE | Single-ended output running |
| se_hiz | output | N_SE | Single-ended output high impedance |
| se_lvl | output | N_SE | Forced single-ended level |
| pd_status | output | 1 | Shutdown in force |

## Verification
Two functions can act on the same edge: shutdown, which forces outputs immediately, and the clock-low gating, which holds any output whose clock is high. The bench provokes this by entering shutdown while every output clock is high, and then by releasing shutdown while the clocks are still high. It checks that entry forces all outputs low at once, that release leaves them held, and that they move only when their own clock drops. Random runs then mix pin toggles, mode changes and per-output clock levels, and compare every output on every cycle against a bench model.

// File: rtl/sdoe_pkg.sv
package sdoe_pkg;

    // Disabled-state selection for one output in enable mode
    typedef enum logic [1:0] {
        DIS_HIZ     = 2'b00,
        DIS_LOW     = 2'b01,
        DIS_HIGH    = 2'b10,
        DIS_HIZ_ALT = 2'b11
    } dis_sel_e;

    // Drive command for one output
    typedef struct packed {
        logic en;
        logic hiz;
        logic lvl;
    } drive_t;

    // Decoded pin meaning
    typedef struct packed {
        logic shut;
        logic run;
    } ctl_t;

    localparam drive_t DRV_OFF = '{en: 1'b0, hiz: 1'b0, lvl: 1'b0};
    localparam drive_t DRV_ON  = '{en: 1'b1, hiz: 1'b0, lvl: 1'b0};

    function automatic drive_t disabled_drive(input dis_sel_e sel);
        drive_t d;
        d = DRV_OFF;
        case (sel)
            DIS_LOW:  d.lvl = 1'b0;
            DIS_HIGH: d.lvl = 1'b1;
            default:  d.hiz = 1'b1;
        endcase
        return d;
    endfunction

    function automatic ctl_t decode_pin(input logic pin_s,
                                        input logic sd_mode,
                                        input logic oe_high);
        ctl_t c;
        c.shut = sd_mode & pin_s;
        if (sd_mode)
            c.run = ~pin_s;
        else
            c.run = oe_high ? pin_s : ~pin_s;
        return c;
    endfunction

endpackage

// File: rtl/sdoe_pin_sync.sv
module sdoe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[LAST-1:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain_q[LAST];

endmodule

// File: rtl/sdoe_mode_decode.sv
module sdoe_mode_decode
    import sdoe_pkg::*;
(
    input  logic pin_s,
    input  logic sd_mode,
    input  logic oe_high,
    output ctl_t ctl
);
    always_comb begin
        ctl = decode_pin(pin_s, sd_mode, oe_high);
    end

    // R2: shutdown and run never both requested
    always_comb begin
        a_r2_shut_excl: assert (!(ctl.shut && ctl.run))
            else $error("shutdown and run both active");
    end

endmodule

// File: rtl/sdoe_out_gate.sv
module sdoe_out_gate
    import sdoe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_lvl,
    input  ctl_t     ctl,
    input  dis_sel_e dis_sel,
    output drive_t   drv
);
    drive_t drv_q;
    drive_t drv_d;

    always_comb begin
        drv_d = drv_q;
        if (ctl.shut)
            drv_d = DRV_OFF;
        else if (!clk_lvl)
            drv_d = ctl.run ? DRV_ON : disabled_drive(dis_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= DRV_OFF;
        else     drv_q <= drv_d;
    end

    assign drv = drv_q;

    a_r7_shut_forces: assert property (@(posedge clk) disable iff (rst)
        $past(ctl.shut) |-> (drv_q == DRV_OFF));

    a_r6_hold_high: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.shut) && $past(clk_lvl)) |-> (drv_q == $past(drv_q)));

    a_r5_no_en_hiz: assert property (@(posedge clk) disable iff (rst)
        !(drv_q.en && drv_q.hiz));

endmodule

// File: rtl/sdoe_ctrl.sv
module sdoe_ctrl
    import sdoe_pkg::*;
#(
    parameter int N_DIFF      = 4,
    parameter int N_SE        = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_pin,
    input  logic                cfg_sd_mode,
    input  logic                cfg_oe_high,
    input  logic [N_DIFF-1:0]   dp_clk_lvl,
    input  logic [N_SE-1:0]     se_clk_lvl,
    input  logic [2*N_DIFF-1:0] dp_dis_sel,
    input  logic [2*N_SE-1:0]   se_dis_sel,
    output logic [N_DIFF-1:0]   dp_en,
    output logic [N_DIFF-1:0]   dp_hiz,
    output logic [N_DIFF-1:0]   dp_lvl,
    output logic [N_SE-1:0]     se_en,
    output logic [N_SE-1:0]     se_hiz,
    output logic [N_SE-1:0]     se_lvl,
    output logic                pd_status
);
    localparam int SEL_W = 2;

    logic pin_s;
    ctl_t ctl;
    logic pd_q;

    sdoe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (ctl_pin),
        .pin_sync  (pin_s)
    );

    sdoe_mode_decode u_dec (
        .pin_s   (pin_s),
        .sd_mode (cfg_sd_mode),
        .oe_high (cfg_oe_high),
        .ctl     (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) pd_q <= 1'b0;
        else     pd_q <= ctl.shut;
    end
    assign pd_status = pd_q;

    generate
        for (genvar i = 0; i < N_DIFF; i++) begin : g_dp
            drive_t d;
            sdoe_out_gate u_gate (
                .clk     (clk),
                .rst     (rst),
                .clk_lvl (dp_clk_lvl[i]),
                .ctl     (ctl),
                .dis_sel (dis_sel_e'(dp_dis_sel[SEL_W*i +: SEL_W])),
                .drv     (d)
            );
            assign dp_en[i]  = d.en;
            assign dp_hiz[i] = d.hiz;
            assign dp_lvl[i] = d.lvl;
        end
        for (genvar j = 0; j < N_SE; j++) begin : g_se
            drive_t d;
            sdoe_out_gate u_gate (
                .clk     (clk),
                .rst     (rst),
                .clk_lvl (se_clk_lvl[j]),
                .ctl     (ctl),
                .dis_sel (dis_sel_e'(se_dis_sel[SEL_W*j +: SEL_W])),
                .drv     (d)
            );
            assign se_en[j]  = d.en;
            assign se_hiz[j] = d.hiz;
            assign se_lvl[j] = d.lvl;
        end
    endgenerate

    // R8: power-down status implies every output held low
    a_r8_pd_all_off: assert property (@(posedge clk) disable iff (rst)
        pd_status |-> (~|{dp_en, dp_hiz, dp_lvl, se_en, se_hiz, se_lvl}));

    // R9: no status during reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !pd_status);

endmodule

// File: tb/sdoe_ctrl_bench.sv
module sdoe_ctrl_bench;
    localparam int ND = 4;
    localparam int NS = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, ctl_pin, cfg_sd_mode, cfg_oe_high;
    logic [ND-1:0]   dp_clk_lvl;
    logic [NS-1:0]   se_clk_lvl;
    logic [2*ND-1:0] dp_dis_sel;
    logic [2*NS-1:0] se_dis_sel;
    logic [ND-1:0]   dp_en, dp_hiz, dp_lvl;
    logic [NS-1:0]   se_en, se_hiz, se_lvl;
    logic            pd_status;

    sdoe_ctrl #(.N_DIFF(ND), .N_SE(NS)) u_sdoe_ctrl (
        .clk(clk), .rst(rst), .ctl_pin(ctl_pin),
        .cfg_sd_mode(cfg_sd_mode), .cfg_oe_high(cfg_oe_high),
        .dp_clk_lvl(dp_clk_lvl), .se_clk_lvl(se_clk_lvl),
        .dp_dis_sel(dp_dis_sel), .se_dis_sel(se_dis_sel),
        .dp_en(dp_en), .dp_hiz(dp_hiz), .dp_lvl(dp_lvl),
        .se_en(se_en), .se_hiz(se_hiz), .se_lvl(se_lvl),
        .pd_status(pd_status)
    );

    int total = 0;
    int bad   = 0;

    // Bench model, bits {en,hiz,lvl}
    bit       s1, s2, m_pd;
    bit [2:0] m_dp [ND];
    bit [2:0] m_se [NS];
    bit       sh, rn;

    function automatic bit [2:0] dis_val(input bit [1:0] s);
        if (s == 2'b01) return 3'b000;
        if (s == 2'b10) return 3'b001;
        return 3'b010;
    endfunction

    function automatic bit [2:0] nxt(input bit [2:0] cur, input bit shut,
                                     input bit run, input bit ck, input bit [1:0] s);
        if (shut) return 3'b000;
        if (!ck)  return run ? 3'b100 : dis_val(s);
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0; s2 <= 1'b0; m_pd <= 1'b0;
            for (int i = 0; i < ND; i++) m_dp[i] <= 3'b000;
            for (int i = 0; i < NS; i++) m_se[i] <= 3'b000;
        end else begin
            sh = cfg_sd_mode && s2;
            rn = !sh && (cfg_sd_mode || (cfg_oe_high ? s2 : !s2));
            s1 <= ctl_pin;
            s2 <= s1;
            m_pd <= sh;
            for (int i = 0; i < ND; i++)
                m_dp[i] <= nxt(m_dp[i], sh, rn, dp_clk_lvl[i], dp_dis_sel[2*i +: 2]);
            for (int i = 0; i < NS; i++)
                m_se[i] <= nxt(m_se[i], sh, rn, se_clk_lvl[i], se_dis_sel[2*i +: 2]);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        for (int i = 0; i < ND; i++)
            chk($sformatf("%s dp%0d", tag, i), {29'd0, dp_en[i], dp_hiz[i], dp_lvl[i]}, {29'd0, m_dp[i]});
        for (int i = 0; i < NS; i++)
            chk($sformatf("%s se%0d", tag, i), {29'd0, se_en[i], se_hiz[i], se_lvl[i]}, {29'd0, m_se[i]});
        chk({tag, " R8 pd"}, {31'd0, pd_status}, {31'd0, m_pd});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D0E));
        rst = 1'b1; ctl_pin = 1'b0; cfg_sd_mode = 1'b0; cfg_oe_high = 1'b0;
        dp_clk_lvl = '0; se_clk_lvl = '0;
        dp_dis_sel = 8'b01_01_01_01; se_dis_sel = 2'b01;
        repeat (3) step();
        // R9 reset state
        chk("R9 reset dp_en", {28'd0, dp_en}, 32'h0);
        chk("R9 reset dp_hiz", {28'd0, dp_hiz}, 32'h0);
        chk("R9 reset dp_lvl", {28'd0, dp_lvl}, 32'h0);
        chk("R9 reset pd", {31'd0, pd_status}, 32'h0);
        rst = 1'b0;
        step();
        chk("R9 R4 low pin runs by default", {28'd0, dp_en}, 32'hF);
        chk("R9 R4 se runs", {31'd0, se_en}, 32'h1);

        // R1 latency
        ctl_pin = 1'b1;
        step(); chk("R1 edge1 unchanged", {28'd0, dp_en}, 32'hF);
        step(); chk("R1 edge2 unchanged", {28'd0, dp_en}, 32'hF);
        step(); chk("R1 edge3 disabled", {28'd0, dp_en}, 32'h0);
        chk("R1 edge3 driven low", {28'd0, dp_hiz | dp_lvl}, 32'h0);
        check_model("R1");

        // R5 disabled-state codes
        dp_dis_sel = 8'b11_10_01_00; se_dis_sel = 2'b10;
        step();
        chk("R5 dp_hiz", {28'd0, dp_hiz}, 32'h9);
        chk("R5 dp_lvl", {28'd0, dp_lvl}, 32'h4);
        chk("R5 dp_en", {28'd0, dp_en}, 32'h0);
        chk("R5 se_lvl", {31'd0, se_lvl}, 32'h1);

        // R4 active-high polarity
        cfg_oe_high = 1'b1;
        step();
        chk("R4 high pol enables", {28'd0, dp_en}, 32'hF);
        chk("R4 running hiz", {28'd0, dp_hiz}, 32'h0);

        // R6 hold while clocks high
        dp_clk_lvl = 4'hF; se_clk_lvl = 1'b1; ctl_pin = 1'b0;
        repeat (4) step();
        chk("R6 held while clock high", {28'd0, dp_en}, 32'hF);
        dp_clk_lvl = 4'h0; se_clk_lvl = 1'b0;
        step();
        chk("R6 update on clock low hiz", {28'd0, dp_hiz}, 32'h9);
        chk("R6 update on clock low en", {28'd0, dp_en}, 32'h0);

        // R10 per-output gating
        dp_clk_lvl = 4'b1010; ctl_pin = 1'b1;
        repeat (3) step();
        chk("R10 only low-clock outputs enable", {28'd0, dp_en}, 32'h5);
        chk("R10 held outputs keep hiz", {28'd0, dp_hiz}, 32'h8);
        chk("R10 se enabled", {31'd0, se_en}, 32'h1);
        check_model("R10");

        // R2 R7 R8 shutdown with every clock high
        dp_clk_lvl = 4'hF; se_clk_lvl = 1'b1; cfg_sd_mode = 1'b1;
        step();
        chk("R2 R7 shutdown forces all", {23'd0, dp_en, dp_hiz, dp_lvl}, 32'h0);
        chk("R7 se forced", {29'd0, se_en, se_hiz, se_lvl}, 32'h0);
        chk("R8 pd on", {31'd0, pd_status}, 32'h1);
        cfg_oe_high = 1'b0;
        step();
        chk("R3 polarity ignored in shutdown", {31'd0, pd_status}, 32'h1);
        // leave shutdown while clocks high
        cfg_oe_high = 1'b1; ctl_pin = 1'b0;
        repeat (3) step();
        chk("R8 pd off", {31'd0, pd_status}, 32'h0);
        chk("R7 release held by clock", {28'd0, dp_en}, 32'h0);
        dp_clk_lvl = 4'h0; se_clk_lvl = 1'b0;
        step();
        chk("R3 low pin runs in sd mode", {28'd0, dp_en}, 32'hF);
        chk("R3 se runs", {31'd0, se_en}, 32'h1);
        check_model("R3");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0)  ctl_pin = ~ctl_pin;
            if ($urandom_range(63) == 0) cfg_sd_mode = ~cfg_sd_mode;
            if ($urandom_range(63) == 0) cfg_oe_high = ~cfg_oe_high;
            if ($urandom_range(15) == 0) begin
                dp_dis_sel = 8'($urandom);
                se_dis_sel = 2'($urandom);
            end
            dp_clk_lvl = 4'($urandom);
            se_clk_lvl = 1'($urandom);
            step();
            check_model("random R2 R4 R5 R6 R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule